// File: doc/BRIEF.md
# Segmented effective address generator

This block works out where one memory operand of a segmented 16-bit processor lives. The decode stage hands it the operand's fields: which base register is used (none, BX or BP), which index register is used (none, SI or DI), and a displacement that may be absent, one byte or one word wide. It also receives the current contents of BX, BP, SI and DI, the four segment registers, and an optional segment override. From these it produces the 16-bit offset, the segment that applies, and the 20-bit linear address.

The default segment follows the base register. A form whose base is BP uses the stack segment. Every other form uses the data segment. An override, when present, replaces that choice. Selector codes that do not name a legal register for their position raise an error flag. A malformed displacement size raises the same flag.

Operands enter on a valid/ready handshake and results leave on another one, through a single register stage. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result that is presented while `out_ready` is low stays unchanged until the consumer takes it.

Top module: `seg_addr_gen`

## Requirements
- R1: `ea_offset` equals displacement + base register value + index register value, modulo 2^16. Absent terms contribute zero. Register select codes are 0 none, 1 BX, 2 BP, 3 SI, 4 DI.
- R2: `disp_kind` chooses the displacement term. A value of 0 means no displacement, and `disp` is then ignored. A value of 1 uses `disp[7:0]`, sign-extended to 16 bits. A value of 2 uses all 16 bits of `disp`.
- R3: With no override and a base select of BP, `ea_seg` is the stack segment (code 2).
- R4: With no override and any base select other than BP, `ea_seg` is the data segment (code 3). This covers BX, index-only and displacement-only forms.
- R5: When `ovr_en` is 1, `ea_seg` equals `ovr_seg` for every addressing form. The segment codes are 0 ES, 1 CS, 2 SS and 3 DS.
- R6: `ea_linear` equals the selected segment value times 16 plus `ea_offset`, truncated to 20 bits.
- R7: `ea_err` is 1 in the following cases, and 0 otherwise:
  - the base select is SI, DI or a code above 4;
  - the index select is BX, BP or a code above 4;
  - `disp_kind` is 3.
- R8: An accepted operand's result appears with `out_valid` high on the next clock edge. While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged and `in_ready` is 0.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand fields are valid |
| in_ready | output | 1 | Block can accept an operand |
| base_sel | input | 3 | Base register select |
| index_sel | input | 3 | Index register select |
| disp_kind | input | 2 | Displacement size code |
| disp | input | 16 | Raw displacement |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| reg_bx | input | 16 | BX contents |
| reg_bp | input | 16 | BP contents |
| reg_si | input | 16 | SI contents |
| reg_di | input | 16 | DI contents |
| seg_es | input | 16 | ES contents |
| seg_cs | input | 16 | CS contents |
| seg_ss | input | 16 | SS contents |
| seg_ds | input | 16 | DS contents |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| ea_offset | output | 16 | Effective offset |
| ea_seg | output | 2 | Selected segment code |
| ea_linear | output | 20 | Linear address |
| ea_err | output | 1 | Illegal form flag |

## Verification
The hardest situation to reach is a stalled output with a second operand already waiting at the input. In that state the held result must not be overwritten. The waiting operand must then be taken on the same edge that the consumer drains the first result.

The stimulus reaches this state in three steps. It drops `out_ready`, sends one operand, and then presents a different one while the first is still held. It checks both results in order once `out_ready` returns.

Wrap-around of both the 16-bit offset and the 20-bit linear address is driven with register and segment values near all-ones.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_BX   = 3'd1,
    RS_BP   = 3'd2,
    RS_SI   = 3'd3,
    RS_DI   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_BYTE = 2'd1,
    DK_WORD = 2'd2,
    DK_BAD  = 2'd3
  } disp_kind_e;

  localparam int NUM_SEGS = 4;
endpackage

// File: rtl/eag_offset.sv
module eag_offset
  import eag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   base_sel,
  input  logic [2:0]   index_sel,
  input  logic [1:0]   disp_kind,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] reg_bx,
  input  logic [W-1:0] reg_bp,
  input  logic [W-1:0] reg_si,
  input  logic [W-1:0] reg_di,
  output logic [W-1:0] offset,
  output logic         err
);
  logic [W-1:0] base_v, idx_v, disp_v;
  logic         base_bad, idx_bad, disp_bad;

  always_comb begin
    base_v   = '0;
    base_bad = 1'b0;
    case (base_sel)
      RS_NONE: base_v = '0;
      RS_BX:   base_v = reg_bx;
      RS_BP:   base_v = reg_bp;
      default: base_bad = 1'b1;
    endcase
  end

  always_comb begin
    idx_v   = '0;
    idx_bad = 1'b0;
    case (index_sel)
      RS_NONE: idx_v = '0;
      RS_SI:   idx_v = reg_si;
      RS_DI:   idx_v = reg_di;
      default: idx_bad = 1'b1;
    endcase
  end

  always_comb begin
    disp_v   = '0;
    disp_bad = 1'b0;
    case (disp_kind)
      DK_NONE: disp_v = '0;
      DK_BYTE: disp_v = {{(W-8){disp[7]}}, disp[7:0]};
      DK_WORD: disp_v = disp;
      default: disp_bad = 1'b1;
    endcase
  end

  assign offset = base_v + idx_v + disp_v;
  assign err    = base_bad | idx_bad | disp_bad;
endmodule

// File: rtl/eag_segsel.sv
module eag_segsel
  import eag_pkg::*;
#(
  parameter int W  = 16,
  parameter int SH = 4,
  localparam int LW = W + SH
) (
  input  logic [2:0]    base_sel,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_seg,
  input  logic [W-1:0]  seg_es,
  input  logic [W-1:0]  seg_cs,
  input  logic [W-1:0]  seg_ss,
  input  logic [W-1:0]  seg_ds,
  input  logic [W-1:0]  offset,
  output logic [1:0]    seg_id,
  output logic [LW-1:0] linear
);
  logic [W-1:0] seg_vals [NUM_SEGS];
  logic [W-1:0] seg_val;

  assign seg_vals[SEG_ES] = seg_es;
  assign seg_vals[SEG_CS] = seg_cs;
  assign seg_vals[SEG_SS] = seg_ss;
  assign seg_vals[SEG_DS] = seg_ds;

  always_comb begin
    if (ovr_en)                    seg_id = ovr_seg;
    else if (base_sel == RS_BP)    seg_id = SEG_SS;
    else                           seg_id = SEG_DS;
  end

  assign seg_val = seg_vals[seg_id];
  assign linear  = {seg_val, {SH{1'b0}}} + {{SH{1'b0}}, offset};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import eag_pkg::*;
#(
  parameter int W  = 16,
  parameter int SH = 4,
  localparam int LW = W + SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    base_sel,
  input  logic [2:0]    index_sel,
  input  logic [1:0]    disp_kind,
  input  logic [W-1:0]  disp,
  input  logic          ovr_en,
  input  logic [1:0]    ovr_seg,
  input  logic [W-1:0]  reg_bx,
  input  logic [W-1:0]  reg_bp,
  input  logic [W-1:0]  reg_si,
  input  logic [W-1:0]  reg_di,
  input  logic [W-1:0]  seg_es,
  input  logic [W-1:0]  seg_cs,
  input  logic [W-1:0]  seg_ss,
  input  logic [W-1:0]  seg_ds,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  ea_offset,
  output logic [1:0]    ea_seg,
  output logic [LW-1:0] ea_linear,
  output logic          ea_err
);
  logic [W-1:0]  off_c;
  logic          err_c;
  logic [1:0]    seg_c;
  logic [LW-1:0] lin_c;
  logic          in_fire;

  eag_offset #(.W(W)) u_off (
    .base_sel (base_sel),
    .index_sel(index_sel),
    .disp_kind(disp_kind),
    .disp     (disp),
    .reg_bx   (reg_bx),
    .reg_bp   (reg_bp),
    .reg_si   (reg_si),
    .reg_di   (reg_di),
    .offset   (off_c),
    .err      (err_c)
  );

  eag_segsel #(.W(W), .SH(SH)) u_seg (
    .base_sel(base_sel),
    .ovr_en  (ovr_en),
    .ovr_seg (ovr_seg),
    .seg_es  (seg_es),
    .seg_cs  (seg_cs),
    .seg_ss  (seg_ss),
    .seg_ds  (seg_ds),
    .offset  (off_c),
    .seg_id  (seg_c),
    .linear  (lin_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea_offset <= '0;
      ea_seg    <= '0;
      ea_linear <= '0;
      ea_err    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea_offset <= off_c;
        ea_seg    <= seg_c;
        ea_linear <= lin_c;
        ea_err    <= err_c;
      end
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea_offset) && $stable(ea_linear) && $stable(ea_seg)); // R8
  AST_BP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !ovr_en && base_sel == RS_BP |=> ea_seg == SEG_SS); // R3
  AST_BX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !ovr_en && base_sel == RS_BX |=> ea_seg == SEG_DS); // R4
  AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && ovr_en |=> ea_seg == $past(ovr_seg)); // R5
  AST_IDX_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (index_sel == RS_BX || index_sel == RS_BP) |=> ea_err); // R7
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  base_sel = 3'd0;
  logic [2:0]  index_sel = 3'd0;
  logic [1:0]  disp_kind = 2'd0;
  logic [15:0] disp = 16'd0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = 2'd0;
  logic [15:0] reg_bx = 16'h1000, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'h0004;
  logic [15:0] seg_es = 16'h4000, seg_cs = 16'h5000, seg_ss = 16'h6000, seg_ds = 16'h7000;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] ea_offset;
  logic [1:0]  ea_seg;
  logic [19:0] ea_linear;
  logic        ea_err;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_sel(base_sel), .index_sel(index_sel), .disp_kind(disp_kind), .disp(disp),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .out_ready(out_ready),
    .ea_offset(ea_offset), .ea_seg(ea_seg), .ea_linear(ea_linear), .ea_err(ea_err)
  );

  logic [15:0] x_off;
  logic [1:0]  x_seg;
  logic [19:0] x_lin;
  logic        x_err;

  task automatic expect_calc();
    logic [15:0] b, i, d, sv;
    b = (base_sel == 3'd1) ? reg_bx : (base_sel == 3'd2) ? reg_bp : 16'd0;
    i = (index_sel == 3'd3) ? reg_si : (index_sel == 3'd4) ? reg_di : 16'd0;
    d = (disp_kind == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : (disp_kind == 2'd2) ? disp : 16'd0;
    x_off = b + i + d;
    x_seg = ovr_en ? ovr_seg : (base_sel == 3'd2) ? 2'd2 : 2'd3;
    case (x_seg)
      2'd0: sv = seg_es;
      2'd1: sv = seg_cs;
      2'd2: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    x_lin = {sv, 4'h0} + {4'h0, x_off};
    x_err = (base_sel > 3'd2) || (index_sel == 3'd1) || (index_sel == 3'd2) ||
            (index_sel > 3'd4) || (disp_kind == 2'd3);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_result(input string req);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk({req, " offset"}, {16'd0, ea_offset}, {16'd0, x_off});
    chk({req, " seg"}, {30'd0, ea_seg}, {30'd0, x_seg});
    chk({req, " linear"}, {12'd0, ea_linear}, {12'd0, x_lin});
    chk({req, " err"}, {31'd0, ea_err}, {31'd0, x_err});
  endtask

  task automatic send(input logic [2:0] b, input logic [2:0] ix, input logic [1:0] dk,
                      input logic [15:0] dv, input logic oe, input logic [1:0] os,
                      input string req);
    @(negedge clk);
    base_sel = b; index_sel = ix; disp_kind = dk; disp = dv; ovr_en = oe; ovr_seg = os;
    in_valid = 1'b1;
    expect_calc();
    @(negedge clk);
    in_valid = 1'b0;
    chk_result(req);
  endtask

  task automatic t_reset();
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_forms();
    send(3'd0, 3'd0, 2'd2, 16'h0100, 1'b0, 2'd0, "R1 R4 disp only");
    chk("R4 disp only seg DS", {30'd0, ea_seg}, 32'd3);
    send(3'd1, 3'd3, 2'd1, 16'h0080, 1'b0, 2'd0, "R2 byte sign extend");
    chk("R2 offset 0x0fb0", {16'd0, ea_offset}, 32'h0fb0);
    send(3'd2, 3'd4, 2'd0, 16'h0000, 1'b0, 2'd0, "R3 BP+DI");
    chk("R3 seg SS", {30'd0, ea_seg}, 32'd2);
    send(3'd2, 3'd3, 2'd2, 16'h0010, 1'b0, 2'd0, "R3 BP+SI+disp");
    send(3'd0, 3'd3, 2'd0, 16'h0000, 1'b0, 2'd0, "R4 SI only");
    send(3'd1, 3'd4, 2'd1, 16'h0005, 1'b0, 2'd0, "R4 BX+DI");
  endtask

  task automatic t_override();
    send(3'd2, 3'd3, 2'd2, 16'h0100, 1'b1, 2'd0, "R5 BP override ES");
    chk("R5 seg ES", {30'd0, ea_seg}, 32'd0);
    send(3'd1, 3'd0, 2'd0, 16'h0000, 1'b1, 2'd2, "R5 BX override SS");
    send(3'd0, 3'd0, 2'd2, 16'h1234, 1'b1, 2'd1, "R5 disp override CS");
    send(3'd2, 3'd0, 2'd0, 16'h0000, 1'b1, 2'd3, "R5 BP override DS");
  endtask

  task automatic t_ignored_disp();
    send(3'd1, 3'd0, 2'd0, 16'hBEEF, 1'b0, 2'd0, "R2 disp ignored");
    chk("R2 offset equals BX", {16'd0, ea_offset}, 32'h1000);
  endtask

  task automatic t_wrap();
    reg_bx = 16'hFFF0; reg_di = 16'h0020;
    send(3'd1, 3'd4, 2'd0, 16'h0000, 1'b0, 2'd0, "R1 offset wrap");
    chk("R1 wrapped offset", {16'd0, ea_offset}, 32'h0010);
    seg_ds = 16'hFFFF; reg_bx = 16'hFFFF;
    send(3'd1, 3'd0, 2'd0, 16'h0000, 1'b0, 2'd0, "R6 linear wrap");
    chk("R6 wrapped linear", {12'd0, ea_linear}, 32'h0FFEF);
    seg_ds = 16'h7000; reg_bx = 16'h1000; reg_di = 16'h0004;
  endtask

  task automatic t_illegal();
    send(3'd0, 3'd1, 2'd0, 16'h0000, 1'b0, 2'd0, "R7 index BX");
    chk("R7 index BX err", {31'd0, ea_err}, 32'd1);
    send(3'd3, 3'd0, 2'd0, 16'h0000, 1'b0, 2'd0, "R7 base SI");
    send(3'd0, 3'd0, 2'd3, 16'h0000, 1'b0, 2'd0, "R7 disp kind 3");
    send(3'd1, 3'd2, 2'd0, 16'h0000, 1'b0, 2'd0, "R7 index BP");
    send(3'd6, 3'd0, 2'd0, 16'h0000, 1'b0, 2'd0, "R7 base code 6");
    send(3'd2, 3'd4, 2'd1, 16'h0001, 1'b0, 2'd0, "R7 legal form err clear");
  endtask

  task automatic t_backpressure();
    logic [15:0] a_off;
    logic [19:0] a_lin;
    @(negedge clk);
    out_ready = 1'b0;
    base_sel = 3'd1; index_sel = 3'd3; disp_kind = 2'd2; disp = 16'h0200; ovr_en = 1'b0;
    in_valid = 1'b1;
    expect_calc();
    a_off = x_off; a_lin = x_lin;
    @(negedge clk);
    chk_result("R8 first held");
    chk("R8 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    base_sel = 3'd2; index_sel = 3'd4; disp_kind = 2'd1; disp = 16'h00F0; ovr_en = 1'b1; ovr_seg = 2'd1;
    @(negedge clk);
    chk("R8 offset held", {16'd0, ea_offset}, {16'd0, a_off});
    chk("R8 linear held", {12'd0, ea_linear}, {12'd0, a_lin});
    chk("R8 seg held DS", {30'd0, ea_seg}, 32'd3);
    out_ready = 1'b1;
    expect_calc();
    @(negedge clk);
    in_valid = 1'b0;
    chk_result("R8 second after drain");
    @(negedge clk);
    chk("R8 valid clears when idle", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #25;
    t_reset();
    rst_n = 1'b1;
    t_forms();
    t_override();
    t_ignored_disp();
    t_wrap();
    t_illegal();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule